// File: doc/BRIEF.md
# Serial SAR Converter Output Emulator

This block stands in for the digital side of a 12-bit successive-approximation converter that talks over a three-wire port. The wires are an active-low select that also acts as shutdown, a serial clock driven by the host, and a data line the emulator can release. The value to be "converted" comes in on a parallel input. It is captured when the select goes low. The emulator then plays back the bit stream a real converter would produce, one falling serial clock edge at a time.

A transaction has a fixed sequence. It begins with a sample phase, during which the data line stays released. On the second falling serial clock edge the output is enabled and drives one low null bit. The result then follows most significant bit first. After that the same result is sent again least significant bit first, without repeating bit 0. Last, the line is held low for as long as the host keeps clocking. A select falling edge seen while the serial clock is high is not a valid start. It is flagged and produces no data. Raising the select ends any transaction at once.

The select and serial clock are sampled on the system clock, and must be synchronous to it and slower than it. Each output change follows the detected serial clock fall by one system clock.

The sequencer is a single state machine:
- IDLE: waits for a select fall. It goes to SAMPLE on a valid start and to REJECT on an invalid one.
- SAMPLE: counts two serial clock falls, then goes to NULL.
- NULL: one fall leads to MSB.
- MSB: steps the bit index down on each fall. After bit 0 it goes to LSB.
- LSB: steps the bit index up from 1. After the top bit it goes to ZERO.
- ZERO: stays until the select rises.
- REJECT: stays until the select rises.

A high select forces IDLE from every state.

Top module: `sar_emu_port`

## Requirements
- R1: A select fall (cs_n 1 to 0) seen while sclk is low starts a transaction. One system clock later, phase reads SAMPLE (1) and start_invalid is 0.
- R2: While cs_n is high, dout_oe is 0 in the same cycle and phase is IDLE (0) from the next system clock on.
- R3: In the sample phase, the first sclk fall leaves phase at SAMPLE with dout_oe 0.
- R4: The second sclk fall gives phase NULL (2) with dout_oe 1 and dout 0.
- R5: Falls 3 to 14 give phase MSB (3) and dout = captured bit 14−n for fall n (B11 down to B0). dout changes one system clock after a detected sclk fall and at no other time while cs_n stays low.
- R6: Falls 15 to 25 give phase LSB (4) and dout = captured bit n−14 (B1 up to B11). Fall 26 and every later fall give phase ZERO (5) with dout_oe 1 and dout 0.
- R7: A select fall seen while sclk is high gives phase REJECT (6) and start_invalid 1, with dout_oe 0 for the whole transaction. start_invalid keeps its value until the next select fall.
- R8: cs_n rising in any phase ends the transaction. A following select fall starts a new transaction from SAMPLE.
- R9: sample_in is captured at the select fall. Changes to it during the transaction have no effect on dout.
- R10: phase only ever takes the codes 0 to 6 listed in R1 to R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Active-low select and shutdown, synchronous to clk |
| sclk | input | 1 | Host serial clock, synchronous to clk |
| sample_in | input | DATA_W | Value reported by the next transaction |
| dout | output | 1 | Serial data (valid when dout_oe is 1) |
| dout_oe | output | 1 | Output enable; 0 means the line is released (high impedance) |
| start_invalid | output | 1 | Last select fall happened with sclk high |
| phase | output | 3 | Sequencer phase code |

## Verification
Every conversion pattern is checked bit by bit across all 28 serial clock falls. The patterns are walking ones, walking zeros, all zeros, all ones, alternating bits and a stride sweep of 64 values. Walking patterns expose any wrong index in the MSB or LSB legs, or any reuse of bit 0. All zeros tells the null bit and zero fill apart from a stuck output enable. The input is inverted right after each select fall, so any read from the live input instead of the captured value shows up as a mismatch. Separate runs cover an invalid start with sclk high, an abort part-way through the MSB leg followed by a clean restart, and a check that dout does not move across rising sclk edges.

// File: rtl/sar_emu_pkg.sv
package sar_emu_pkg;
    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_SAMPLE = 3'd1,
        PH_NULL   = 3'd2,
        PH_MSB    = 3'd3,
        PH_LSB    = 3'd4,
        PH_ZERO   = 3'd5,
        PH_REJECT = 3'd6
    } phase_e;
endpackage

// File: rtl/sar_emu_edges.sv
module sar_emu_edges #(
    parameter int          N       = 2,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] sig,
    output logic [N-1:0] fall
);
    logic [N-1:0] sig_q;

    for (genvar g = 0; g < N; g++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n) sig_q[g] <= RST_VAL[g];
            else        sig_q[g] <= sig[g];
        end
        assign fall[g] = sig_q[g] & ~sig[g];
    end
endmodule

// File: rtl/sar_emu_fsm.sv
module sar_emu_fsm
    import sar_emu_pkg::*;
#(
    parameter int DATA_W = 12,
    localparam int IDX_W = $clog2(DATA_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             sclk,
    input  logic             cs_fall,
    input  logic             sclk_fall,
    output phase_e           phase,
    output logic [IDX_W-1:0] bit_idx,
    output logic             start_invalid,
    output logic             load
);
    localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(DATA_W - 1);

    phase_e           state_q, state_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic             flag_q, flag_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PH_IDLE;
            idx_q   <= '0;
            flag_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            flag_q  <= flag_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        flag_d  = flag_q;
        if (cs_n) begin
            state_d = PH_IDLE;
            idx_d   = '0;
        end else begin
            unique case (state_q)
                PH_IDLE: begin
                    if (cs_fall) begin
                        flag_d  = sclk;
                        idx_d   = '0;
                        state_d = sclk ? PH_REJECT : PH_SAMPLE;
                    end
                end
                PH_SAMPLE: begin
                    if (sclk_fall) begin
                        if (idx_q == '0) idx_d = IDX_W'(1);
                        else             state_d = PH_NULL;
                    end
                end
                PH_NULL: begin
                    if (sclk_fall) begin
                        state_d = PH_MSB;
                        idx_d   = TOP_IDX;
                    end
                end
                PH_MSB: begin
                    if (sclk_fall) begin
                        if (idx_q == '0) begin
                            state_d = PH_LSB;
                            idx_d   = IDX_W'(1);
                        end else begin
                            idx_d = idx_q - IDX_W'(1);
                        end
                    end
                end
                PH_LSB: begin
                    if (sclk_fall) begin
                        if (idx_q == TOP_IDX) state_d = PH_ZERO;
                        else                  idx_d   = idx_q + IDX_W'(1);
                    end
                end
                PH_ZERO, PH_REJECT: begin
                    state_d = state_q;
                end
                default: state_d = PH_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        phase         = state_q;
        bit_idx       = idx_q;
        start_invalid = flag_q;
        load          = (state_q == PH_IDLE) && !cs_n && cs_fall;
    end
endmodule

// File: rtl/sar_emu_serializer.sv
module sar_emu_serializer
    import sar_emu_pkg::*;
#(
    parameter int DATA_W = 12,
    localparam int IDX_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              load,
    input  logic [DATA_W-1:0] sample_in,
    input  phase_e            phase,
    input  logic [IDX_W-1:0]  bit_idx,
    output logic              dout,
    output logic              dout_oe
);
    logic [DATA_W-1:0] held_q;

    always_ff @(posedge clk) begin
        if (!rst_n)    held_q <= '0;
        else if (load) held_q <= sample_in;
    end

    always_comb begin
        dout    = 1'b0;
        dout_oe = 1'b0;
        unique case (phase)
            PH_MSB, PH_LSB: begin
                dout    = held_q[bit_idx];
                dout_oe = !cs_n;
            end
            PH_NULL, PH_ZERO: dout_oe = !cs_n;
            default: dout_oe = 1'b0;
        endcase
    end
endmodule

// File: rtl/sar_emu_port.sv
module sar_emu_port
    import sar_emu_pkg::*;
#(
    parameter int DATA_W = 12,
    localparam int IDX_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic [DATA_W-1:0] sample_in,
    output logic              dout,
    output logic              dout_oe,
    output logic              start_invalid,
    output logic [2:0]        phase
);
    logic [1:0]       falls;
    phase_e           ph;
    logic [IDX_W-1:0] bit_idx;
    logic             load;

    // bit 0: select (resets high), bit 1: serial clock (resets low)
    sar_emu_edges #(.N(2), .RST_VAL(2'b01)) u_edges (
        .clk   (clk),
        .rst_n (rst_n),
        .sig   ({sclk, cs_n}),
        .fall  (falls)
    );

    sar_emu_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .cs_n          (cs_n),
        .sclk          (sclk),
        .cs_fall       (falls[0]),
        .sclk_fall     (falls[1]),
        .phase         (ph),
        .bit_idx       (bit_idx),
        .start_invalid (start_invalid),
        .load          (load)
    );

    sar_emu_serializer #(.DATA_W(DATA_W)) u_ser (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .load      (load),
        .sample_in (sample_in),
        .phase     (ph),
        .bit_idx   (bit_idx),
        .dout      (dout),
        .dout_oe   (dout_oe)
    );

    assign phase = ph;
endmodule

// File: rtl/sar_emu_port_chk.sv
module sar_emu_port_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_n,
    input logic       sclk,
    input logic       dout,
    input logic       dout_oe,
    input logic       start_invalid,
    input logic [2:0] phase
);
    p_hiz_deselected_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !dout_oe);

    p_idle_after_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> (phase == 3'd0));

    p_valid_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cs_n) && !sclk) |=> (phase == 3'd1 && !start_invalid));

    p_invalid_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cs_n) && sclk) |=> (phase == 3'd6 && start_invalid && !dout_oe));

    p_null_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 3'd2 && !cs_n) |-> (dout_oe && !dout));

    p_zero_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 3'd5 && !cs_n) |-> (dout_oe && !dout));

    p_change_on_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !$past(cs_n) && !($past(sclk, 2) && !$past(sclk))) |-> $stable(dout));

    p_legal_phase_r10: assert property (@(posedge clk) disable iff (!rst_n)
        phase != 3'd7);
endmodule

bind sar_emu_port sar_emu_port_chk u_chk (.*);

// File: tb/sar_emu_port_tb.sv
module sar_emu_port_tb;
    localparam int W  = 12;
    localparam int HP = 3;   // sclk half period in system clocks

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cs_n = 1'b1;
    logic         sclk = 1'b0;
    logic [W-1:0] sample_in = '0;
    logic         dout, dout_oe, start_invalid;
    logic [2:0]   phase;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #10 clk = ~clk;

    sar_emu_port #(.DATA_W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk),
        .sample_in(sample_in), .dout(dout), .dout_oe(dout_oe),
        .start_invalid(start_invalid), .phase(phase)
    );

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #5;
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // expected {phase, oe, dout} after fall number i
    function automatic logic [4:0] expect_after(input logic [W-1:0] v, input int i);
        if (i == 1)          return {3'd1, 1'b0, 1'b0};
        if (i == 2)          return {3'd2, 1'b1, 1'b0};
        if (i <= W + 2)      return {3'd3, 1'b1, v[W + 2 - i]};
        if (i <= 2 * W + 1)  return {3'd4, 1'b1, v[i - (W + 2)]};
        return {3'd5, 1'b1, 1'b0};
    endfunction

    task automatic run_conv(input logic [W-1:0] v, input int nfalls);
        logic [4:0] e;
        logic [4:0] prev;
        sample_in = v;
        sclk = 1'b0;
        step(2);
        cs_n = 1'b0;
        step(1);
        chk(phase == 3'd1 && !start_invalid && !dout_oe, "R1", "start",
            {phase, start_invalid, dout_oe}, {3'd1, 2'b00});
        sample_in = ~v;  // R9: must be ignored
        prev = {3'd1, 1'b0, 1'b0};
        for (int i = 1; i <= nfalls; i++) begin
            sclk = 1'b1;
            step(HP);
            chk({phase, dout_oe, dout} == prev, "R5", "held across rise",
                {phase, dout_oe, dout}, prev);
            sclk = 1'b0;
            step(1);
            e = expect_after(v, i);
            chk({phase, dout_oe, dout} == e,
                (i == 1) ? "R3" : (i == 2) ? "R4" : (i <= W + 2) ? "R5 R9" : "R6 R9",
                $sformatf("fall %0d value %0h", i, v), {phase, dout_oe, dout}, e);
            prev = e;
            step(HP - 1);
        end
        cs_n = 1'b1;
        #1;
        chk(!dout_oe, "R2 R8", "oe release at select rise", dout_oe, 0);
        step(1);
        chk(phase == 3'd0 && !dout_oe, "R2", "idle after rise", phase, 0);
    endtask

    initial begin
        step(3);
        chk(phase == 3'd0 && !dout_oe && !start_invalid, "R2 R10", "reset state",
            {phase, dout_oe, start_invalid}, 0);
        rst_n = 1'b1;
        step(2);
        chk(phase == 3'd0 && !dout_oe, "R2", "idle after reset", phase, 0);

        // main patterns
        run_conv('0, 2 * W + 4);
        run_conv('1, 2 * W + 4);
        run_conv(12'hAAA, 2 * W + 4);
        run_conv(12'h555, 2 * W + 4);
        for (int b = 0; b < W; b++) run_conv(W'(1) << b, 2 * W + 4);
        for (int b = 0; b < W; b++) run_conv(~(W'(1) << b), 2 * W + 4);
        for (int k = 0; k < 64; k++) run_conv(W'((k * 37 + 5) % 4096), 2 * W + 4);

        // R8: abort inside MSB leg, then clean restart
        run_conv(12'hC3A, 7);
        run_conv(12'h3C5, 2 * W + 4);

        // R7: invalid start with sclk high
        sclk = 1'b1;
        step(2);
        sample_in = 12'hFFF;
        cs_n = 1'b0;
        step(1);
        chk(phase == 3'd6 && start_invalid && !dout_oe, "R7", "reject entry",
            {phase, start_invalid, dout_oe}, {3'd6, 2'b10});
        for (int i = 0; i < 6; i++) begin
            sclk = 1'b0; step(HP);
            sclk = 1'b1; step(HP);
            chk(phase == 3'd6 && !dout_oe, "R7", "reject holds",
                {phase, dout_oe}, {3'd6, 1'b0});
        end
        cs_n = 1'b1;
        step(1);
        chk(start_invalid && phase == 3'd0, "R7", "flag kept after rise",
            {phase, start_invalid}, {3'd0, 1'b1});
        run_conv(12'h5A3, 2 * W + 4);  // R1 clears flag

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule